// File: doc/BRIEF.md
# Pairwise Widening Add Unit

This block takes a 128-bit vector and splits it into narrow lanes of 8, 16 or 32 bits. Each pair of neighbouring lanes is widened to twice the lane width and added, so the result holds half as many lanes, each twice as wide. The narrow lanes are widened by sign extension or by zero extension, as selected by a mode input.

In accumulate mode the pair sums are added lane by lane to a second 128-bit vector at the wide lane width. These additions wrap and do not saturate. In half-width mode the upper 64 bits of the result are forced to zero.

A request is accepted through a valid/ready handshake. The result is held in an output register that has its own valid/ready handshake. A new request can be accepted in the same cycle as the held result is taken.

Top module: `pairsum_widen_unit`

## Requirements
- R1: With `lane_code` 0, 1 or 2 the narrow lanes are 8, 16 or 32 bits wide. Narrow lane 0 sits at bit 0. Wide result lane i is the sum of narrow lanes 2i and 2i+1, each zero-extended when `is_signed` is 0.
- R2: When `is_signed` is 1, both narrow lanes of each pair are sign-extended before they are added.
- R3: When `acc_en` is 1, wide lane i of `dst_vec` is added to each pair sum. The sum wraps modulo 2 to the power of the wide lane width, and no carry crosses into a neighbouring lane.
- R4: When `full_width` is 0, bits 127:64 of `out_vec` are zero. When it is 1, those bits carry the computed lanes.
- R5: `lane_code` 3 is illegal. The request is still accepted, but the result has `out_err` at 1 and `out_vec` all zero. Legal codes give `out_err` at 0.
- R6: The result of a request accepted on one rising edge appears on `out_vec` with `out_valid` high after that same edge. `out_valid` falls after an edge where the result was taken and no new request arrived.
- R7: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and `out_valid`, `out_vec` and `out_err` hold their values.
- R8: `in_ready` is 1 whenever the output register is empty or `out_ready` is 1. A held result can therefore be taken and a new request loaded on the same edge.
- R9: After a synchronous active-low reset, `out_valid` is 0, `out_err` is 0, `out_vec` is zero and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| src_vec | input | 128 | Vector whose lane pairs are summed |
| dst_vec | input | 128 | Vector added in accumulate mode |
| lane_code | input | 2 | Narrow lane size: 0=8, 1=16, 2=32 bits, 3 illegal |
| is_signed | input | 1 | 1 selects sign extension, 0 selects zero extension |
| acc_en | input | 1 | Add `dst_vec` to the pair sums |
| full_width | input | 1 | 0 clears result bits 127:64 |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_vec | output | 128 | Registered result |
| out_err | output | 1 | Result came from an illegal lane code |

## Verification
The two events that can share a clock edge are the consumer taking the held result and a new request being captured. The bench provokes this in two ways. It streams requests back to back with `out_ready` held high. It also stalls the output with a request waiting, then raises `out_ready`. Each case is judged by checking that every result appears exactly once, on the sample after its own request, with the value the bench computes by arithmetic. The held value must stay frozen for as long as the stall lasts.

// File: rtl/pw_pkg.sv
// Shared constants and the lane-size code type for the pairwise widening add unit.
// Assumes a 128-bit datapath and three legal narrow lane sizes that double from 8 bits.
package pw_pkg;
    localparam int VEC_W     = 128;
    localparam int BASE_W    = 8;
    localparam int NUM_SIZES = 3;

    typedef enum logic [1:0] {
        LANE_8  = 2'd0,
        LANE_16 = 2'd1,
        LANE_32 = 2'd2,
        LANE_NA = 2'd3
    } lane_code_e;
endpackage

// File: rtl/pw_lane_block.sv
// Pair-sum datapath for one fixed narrow lane width.
// Each pair of narrow lanes is widened to the double width and added. In
// accumulate mode the matching wide lane of dst is added as well. Each lane
// wraps within its own width. Assumes VEC_W is a multiple of 2*NARROW_W.
module pw_lane_block #(
    parameter int VEC_W    = 128,
    parameter int NARROW_W = 8
) (
    input  logic [VEC_W-1:0] src,
    input  logic [VEC_W-1:0] dst,
    input  logic             is_signed,
    input  logic             acc_en,
    output logic [VEC_W-1:0] res
);
    localparam int WIDE_W = 2 * NARROW_W;
    localparam int LANES  = VEC_W / WIDE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [NARROW_W-1:0] ev, od;
        logic [WIDE_W-1:0]   ev_x, od_x, acc_x;

        assign ev   = src[g*WIDE_W +: NARROW_W];
        assign od   = src[g*WIDE_W + NARROW_W +: NARROW_W];
        // widen each half of the pair according to the sign mode
        assign ev_x = {{NARROW_W{is_signed & ev[NARROW_W-1]}}, ev};
        assign od_x = {{NARROW_W{is_signed & od[NARROW_W-1]}}, od};
        // optional accumulate term at the wide width
        assign acc_x = acc_en ? dst[g*WIDE_W +: WIDE_W] : '0;
        assign res[g*WIDE_W +: WIDE_W] = ev_x + od_x + acc_x;
    end
endmodule

// File: rtl/pw_size_select.sv
// Picks the candidate result that matches the lane code and applies the half-width mask.
// Candidate s sits at slice s of the flat bus. A code with no candidate
// gives zero and raises the error flag.
module pw_size_select #(
    parameter int VEC_W     = 128,
    parameter int NUM_SIZES = 3
) (
    input  logic [NUM_SIZES*VEC_W-1:0] cand,
    input  logic [1:0]                 lane_code,
    input  logic                       full_width,
    output logic [VEC_W-1:0]           sel_vec,
    output logic                       sel_err
);
    localparam int HALF_W = VEC_W / 2;

    // choose one candidate by code, then clear the upper half when required
    always_comb begin
        sel_vec = '0;
        sel_err = 1'b1;
        for (int s = 0; s < NUM_SIZES; s++) begin
            if (int'(lane_code) == s) begin
                sel_vec = cand[s*VEC_W +: VEC_W];
                sel_err = 1'b0;
            end
        end
        if (!full_width) sel_vec[VEC_W-1:HALF_W] = '0;
    end
endmodule

// File: rtl/pw_result_stage.sv
// One-entry output register with a valid/ready handshake on both sides.
// It accepts a new entry when it is empty or when its entry is taken on the
// same edge. Reset is synchronous and active low.
module pw_result_stage #(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [VEC_W-1:0] d_vec,
    input  logic             d_err,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [VEC_W-1:0] out_vec,
    output logic             out_err
);
    logic take;

    // ready when empty or being drained this cycle
    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;

    // valid flag: set on capture, cleared when drained with nothing new
    always_ff @(posedge clk) begin
        if (!rst_n)         out_valid <= 1'b0;
        else if (take)      out_valid <= 1'b1;
        else if (out_ready) out_valid <= 1'b0;
    end

    // data register: loaded only on capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vec <= '0;
            out_err <= 1'b0;
        end else if (take) begin
            out_vec <= d_vec;
            out_err <= d_err;
        end
    end
endmodule

// File: rtl/pairsum_widen_unit.sv
// Top level of the pairwise widening add unit.
// It builds one pair-sum datapath for each legal lane size, selects the one
// named by lane_code, masks the upper half if required and registers the
// result. It assumes a single clock with a synchronous active-low reset.
module pairsum_widen_unit #(
    parameter int VEC_W     = pw_pkg::VEC_W,
    parameter int BASE_W    = pw_pkg::BASE_W,
    parameter int NUM_SIZES = pw_pkg::NUM_SIZES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [VEC_W-1:0] src_vec,
    input  logic [VEC_W-1:0] dst_vec,
    input  logic [1:0]       lane_code,
    input  logic             is_signed,
    input  logic             acc_en,
    input  logic             full_width,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [VEC_W-1:0] out_vec,
    output logic             out_err
);
    logic [NUM_SIZES*VEC_W-1:0] cand;
    logic [VEC_W-1:0]           sel_vec;
    logic                       sel_err;

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        pw_lane_block #(
            .VEC_W   (VEC_W),
            .NARROW_W(BASE_W << s)
        ) u_lanes (
            .src      (src_vec),
            .dst      (dst_vec),
            .is_signed(is_signed),
            .acc_en   (acc_en),
            .res      (cand[s*VEC_W +: VEC_W])
        );
    end

    pw_size_select #(
        .VEC_W    (VEC_W),
        .NUM_SIZES(NUM_SIZES)
    ) u_sel (
        .cand      (cand),
        .lane_code (lane_code),
        .full_width(full_width),
        .sel_vec   (sel_vec),
        .sel_err   (sel_err)
    );

    pw_result_stage #(
        .VEC_W(VEC_W)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .d_vec    (sel_vec),
        .d_err    (sel_err),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_vec  (out_vec),
        .out_err  (out_err)
    );
endmodule

// File: rtl/pw_checker.sv
// Temporal checks on the ports of the pairwise widening add unit.
// It is attached to every instance of the top module by the bind at the end of this file.
module pw_checker #(
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [1:0]       lane_code,
    input logic             full_width,
    input logic             out_valid,
    input logic             out_ready,
    input logic [VEC_W-1:0] out_vec,
    input logic             out_err
);
    localparam int HALF_W = VEC_W / 2;

    // R6
    fire_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_vec) && $stable(out_err));

    // R4
    half_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !full_width |=> out_vec[VEC_W-1:HALF_W] == '0);

    // R5
    illegal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && lane_code == 2'd3 |=> out_err && out_vec == '0);

    // R5
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && lane_code != 2'd3 |=> !out_err);

    // R8
    empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);
endmodule

bind pairsum_widen_unit pw_checker #(.VEC_W(VEC_W)) u_pw_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .lane_code (lane_code),
    .full_width(full_width),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_vec   (out_vec),
    .out_err   (out_err)
);

// File: tb/tb_pairsum_widen_unit.sv
`timescale 1ns/1ps
module tb_pairsum_widen_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] src_vec = '0;
    logic [127:0] dst_vec = '0;
    logic [1:0]   lane_code = '0;
    logic         is_signed = 1'b0;
    logic         acc_en = 1'b0;
    logic         full_width = 1'b1;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [127:0] out_vec;
    logic         out_err;

    int checks = 0;
    int errors = 0;
    logic [63:0] rs = 64'h9E37_79B9_7F4A_7C15;

    always #4 clk = ~clk;

    pairsum_widen_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .src_vec(src_vec), .dst_vec(dst_vec), .lane_code(lane_code),
        .is_signed(is_signed), .acc_en(acc_en), .full_width(full_width),
        .out_valid(out_valid), .out_ready(out_ready), .out_vec(out_vec),
        .out_err(out_err)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 7);
        rs = rs ^ (rs << 17);
        return rs;
    endfunction

    // arithmetic reference: widened pair sums, optional wrapped accumulate, half mask
    function automatic logic [127:0] model(input logic [127:0] s, input logic [127:0] d,
                                           input logic [1:0] c, input logic sg,
                                           input logic ac, input logic fl);
        logic [127:0] r, m_n, m_w, a, b, w;
        int nw;
        r = '0;
        if (c == 2'd3) return '0;
        nw  = 8 << c;
        m_n = (128'd1 << nw) - 128'd1;
        m_w = (128'd1 << (2 * nw)) - 128'd1;
        for (int i = 0; i < 128 / (2 * nw); i++) begin
            a = (s >> (2 * i * nw)) & m_n;
            b = (s >> ((2 * i + 1) * nw)) & m_n;
            if (sg && a[nw-1]) a = a | ~m_n;
            if (sg && b[nw-1]) b = b | ~m_n;
            w = (a + b + (ac ? ((d >> (2 * i * nw)) & m_w) : 128'd0)) & m_w;
            r = r | (w << (2 * i * nw));
        end
        if (!fl) r[127:64] = '0;
        return r;
    endfunction

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic         pend;
        logic [127:0] exp_v, exp_a, exp_b;
        logic         exp_e, exp_fl;
        string        tag;
        pend = 1'b0; exp_v = '0; exp_e = 1'b0; exp_fl = 1'b1; tag = "R1";

        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 out_valid", {127'd0, out_valid}, 128'd0);
        chk("R9 out_vec", out_vec, 128'd0);
        chk("R9 out_err", {127'd0, out_err}, 128'd0);
        chk("R9 in_ready", {127'd0, in_ready}, 128'd1);
        rst_n = 1'b1;

        // sweep of every mode combination, streamed back to back (R8 overlap)
        for (int c = 0; c < 4; c++)
        for (int sg = 0; sg < 2; sg++)
        for (int ac = 0; ac < 2; ac++)
        for (int fl = 0; fl < 2; fl++)
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (pend) begin
                chk({tag, " out_vec"}, out_vec, exp_v);
                chk("R6 out_valid", {127'd0, out_valid}, 128'd1);
                chk("R5 out_err", {127'd0, out_err}, {127'd0, exp_e});
                if (!exp_fl) chk("R4 upper half", {64'd0, out_vec[127:64]}, 128'd0);
            end
            chk("R8 in_ready streaming", {127'd0, in_ready}, 128'd1);
            case (k)
                0: begin src_vec = '1;            dst_vec = '1; end
                1: begin src_vec = {16{8'h80}};   dst_vec = {4{32'h7FFF_FFFF}}; end
                2: begin src_vec = {16{8'h7F}};   dst_vec = {2{64'hFFFF_FFFF_FFFF_FFF0}}; end
                default: begin src_vec = {rnd(), rnd()}; dst_vec = {rnd(), rnd()}; end
            endcase
            lane_code  = c[1:0];
            is_signed  = sg[0];
            acc_en     = ac[0];
            full_width = fl[0];
            in_valid   = 1'b1;
            exp_v  = model(src_vec, dst_vec, c[1:0], sg[0], ac[0], fl[0]);
            exp_e  = (c == 3);
            exp_fl = fl[0];
            tag    = (c == 3) ? "R5" : (ac != 0) ? "R3" : (sg != 0) ? "R2" : "R1";
            pend   = 1'b1;
        end
        @(negedge clk);
        chk({tag, " out_vec last"}, out_vec, exp_v);
        in_valid = 1'b0;
        @(negedge clk);
        // R6 valid drops after drain with no new request
        chk("R6 out_valid drop", {127'd0, out_valid}, 128'd0);

        // stall with a waiting request, then release (R7, R8)
        out_ready  = 1'b0;
        lane_code  = 2'd1; is_signed = 1'b1; acc_en = 1'b1; full_width = 1'b1;
        src_vec    = {rnd(), rnd()}; dst_vec = {rnd(), rnd()};
        exp_a      = model(src_vec, dst_vec, 2'd1, 1'b1, 1'b1, 1'b1);
        in_valid   = 1'b1;
        @(negedge clk);
        lane_code  = 2'd0; is_signed = 1'b0; acc_en = 1'b0;
        src_vec    = {rnd(), rnd()}; dst_vec = {rnd(), rnd()};
        exp_b      = model(src_vec, dst_vec, 2'd0, 1'b0, 1'b0, 1'b1);
        for (int h = 0; h < 3; h++) begin
            chk("R7 held out_vec", out_vec, exp_a);
            chk("R7 held out_valid", {127'd0, out_valid}, 128'd1);
            chk("R7 in_ready low", {127'd0, in_ready}, 128'd0);
            @(negedge clk);
        end
        out_ready = 1'b1;
        #1;
        chk("R8 in_ready on drain", {127'd0, in_ready}, 128'd1);
        @(negedge clk);
        chk("R8 next result", out_vec, exp_b);
        chk("R8 out_valid", {127'd0, out_valid}, 128'd1);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R6 out_valid idle", {127'd0, out_valid}, 128'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule